// File: doc/BRIEF.md
# Pipelined DMA Bus Arbiter

This block shares one 16-bit access bus among several DMA master channels. Each channel raises a request and holds an address, a transfer width (16 or 32 bits) and a 32-bit write word. The arbiter picks one channel at a time using a software-programmed rank per channel. It then sequences the data phase onto the narrow bus, splitting a 32-bit transfer into two halves.

Arbitration for the next transfer runs in the last data beat of the current one. A waiting channel therefore takes the bus in the very next cycle, and back-to-back traffic from different channels runs with no dead cycle. Each channel sees a one-cycle grant pulse when its transfer is accepted, and a strobe on every beat it owns.

Rank writes go into a shadow copy. The arbiter copies the shadow into the active ranking only at an arbitration point. A transfer in flight is therefore never re-ranked halfway through.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `gnt_o`, `dvalid_o`, `bus_valid_o` and `bus_hi_o` are all zero.
- R2: At most one bit of `gnt_o` is set in any cycle. A grant bit is high for exactly one cycle per accepted transfer. That cycle is the first (low-half) beat of the same master's data phase.
- R3: With the bus idle, a request seen in cycle t is granted in cycle t+1.
- R4: Master i's rank is the 3-bit field `rank_i[3i+2:3i]`. Among eligible requesters, the lowest rank value wins, and equal values go to the lower master index. After reset, master i's rank is i.
- R5: A 16-bit transfer (`wide_i`=0) takes one beat. The beat drives the master's address on `bus_addr_o` and bits 15:0 of its write word on `bus_wdata_o`, with `bus_hi_o`=0.
- R6: A 32-bit transfer (`wide_i`=1) takes two consecutive beats by the same owner with no grant between them. The first beat carries bits 15:0 at the given address with `bus_hi_o`=0. The second beat carries bits 31:16 at that address plus 2, with `bus_hi_o`=1.
- R7: The arbitration for the next transfer happens during the last beat of the current one. If any master is eligible then, the next data phase starts in the following cycle with no idle cycle.
- R8: A rank write (`rank_wr_i`=1) goes into a shadow copy at the end of its cycle. The shadow becomes the active ranking at the end of the next cycle that is an arbitration point (bus idle or last beat). The arbitration made in that same cycle still uses the old ranking.
- R9: `dvalid_o` is one-hot on the owner's bit in every cycle where `bus_valid_o` is high, and zero otherwise.
- R10: Address, width and write word are taken in the arbitration cycle. In the cycle its grant is high, a master is not eligible. A request still held after that cycle asks for a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NM | Request per master |
| wide_i | input | NM | 1 = 32-bit transfer, 0 = 16-bit, per master |
| addr_i | input | NM*AW | Byte address per master, master i at bits [i*AW +: AW] |
| wdata_i | input | NM*2*BW | Write word per master, master i at bits [i*2*BW +: 2*BW] |
| rank_wr_i | input | 1 | Rank write strobe |
| rank_i | input | NM*PW | New rank fields, master i at bits [i*PW +: PW] |
| gnt_o | output | NM | One-cycle acceptance pulse per master |
| dvalid_o | output | NM | Per-beat strobe to the owning master |
| bus_valid_o | output | 1 | A data beat is on the bus |
| bus_hi_o | output | 1 | Current beat is the upper half of a 32-bit transfer |
| bus_addr_o | output | AW | Beat address |
| bus_wdata_o | output | BW | Beat write data |

## Verification
The bench builds the block with its defaults: four masters, 3-bit rank fields, a 16-bit address and a 16-bit bus. With four masters and eight rank values, full ties, a fully reversed ranking and mixed widths can all be set up. Random rank rewrites can also land in any beat of a transfer. These cases reach the shadow-to-active hand-over in both the idle and the last-beat kind of arbitration point. They also reach the exclusion of a master in its own grant cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // Byte distance between the two halves of a 32-bit transfer on a 16-bit bus.
  localparam int unsigned HALF_BYTE_STEP = 2;

  typedef enum logic {BEAT_LO = 1'b0, BEAT_HI = 1'b1} beat_e;
endpackage

// File: rtl/arb_rank_regs.sv
module arb_rank_regs #(
  parameter int NM = 4,
  parameter int PW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [NM*PW-1:0] wr_ranks,
  input  logic           apply,
  output logic [NM*PW-1:0] active
);
  logic [NM*PW-1:0] shadow;

  function automatic logic [NM*PW-1:0] reset_ranks();
    logic [NM*PW-1:0] r;
    r = '0;
    for (int i = 0; i < NM; i++) r[i*PW +: PW] = PW'(i);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= reset_ranks();
      active <= reset_ranks();
    end else begin
      if (wr)    shadow <= wr_ranks;
      if (apply) active <= shadow;
    end
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int NM = 4,
  parameter int PW = 3,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic [NM-1:0]    elig,
  input  logic [NM*PW-1:0] ranks,
  output logic             any,
  output logic [IW-1:0]    win
);
  logic [PW-1:0] best;

  // Strict less-than keeps the lower index on a tie.
  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '1;
    for (int i = 0; i < NM; i++) begin
      if (elig[i] && (!any || ranks[i*PW +: PW] < best)) begin
        any  = 1'b1;
        best = ranks[i*PW +: PW];
        win  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/arb_beat_seq.sv
module arb_beat_seq
  import dma_arb_pkg::*;
#(
  parameter int NM = 4,
  parameter int AW = 16,
  parameter int BW = 16,
  localparam int WW = 2 * BW,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] start_idx,
  input  logic          start_wide,
  input  logic [AW-1:0] start_addr,
  input  logic [WW-1:0] start_data,
  output logic          busy,
  output logic          last_beat,
  output logic          cur_wide,
  output beat_e         beat,
  output logic [NM-1:0] gnt,
  output logic [NM-1:0] dvalid,
  output logic [AW-1:0] addr_out,
  output logic [BW-1:0] data_out
);
  logic [IW-1:0] owner;
  logic [AW-1:0] addr_q;
  logic [WW-1:0] data_q;

  function automatic logic [NM-1:0] idx_to_mask(input logic [IW-1:0] idx);
    logic [NM-1:0] m;
    m = '0;
    for (int i = 0; i < NM; i++) m[i] = (idx == IW'(i));
    return m;
  endfunction

  function automatic logic [AW-1:0] upper_half_addr(input logic [AW-1:0] a);
    return a + AW'(HALF_BYTE_STEP);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      beat     <= BEAT_LO;
      owner    <= '0;
      cur_wide <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      gnt      <= '0;
    end else begin
      gnt <= '0;
      if (start) begin
        busy     <= 1'b1;
        beat     <= BEAT_LO;
        owner    <= start_idx;
        cur_wide <= start_wide;
        addr_q   <= start_addr;
        data_q   <= start_data;
        gnt      <= idx_to_mask(start_idx);
      end else if (busy && !last_beat) begin
        beat <= BEAT_HI;
      end else begin
        busy <= 1'b0;
        beat <= BEAT_LO;
      end
    end
  end

  assign last_beat = busy && (!cur_wide || beat == BEAT_HI);
  assign dvalid    = busy ? idx_to_mask(owner) : '0;
  assign addr_out  = (beat == BEAT_HI) ? upper_half_addr(addr_q) : addr_q;
  assign data_out  = (beat == BEAT_HI) ? data_q[WW-1:BW] : data_q[BW-1:0];
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NM = 4,
  parameter int AW = 16,
  parameter int PW = 3,
  parameter int BW = 16,
  localparam int WW = 2 * BW,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    req_i,
  input  logic [NM-1:0]    wide_i,
  input  logic [NM*AW-1:0] addr_i,
  input  logic [NM*WW-1:0] wdata_i,
  input  logic             rank_wr_i,
  input  logic [NM*PW-1:0] rank_i,
  output logic [NM-1:0]    gnt_o,
  output logic [NM-1:0]    dvalid_o,
  output logic             bus_valid_o,
  output logic             bus_hi_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [BW-1:0]    bus_wdata_o
);
  // Named internal events, used by the bound checker.
  logic             busy;
  logic             last_beat;
  logic             cur_wide;
  logic             arb_point;
  logic             grant_now;
  logic [NM-1:0]    elig;
  logic [IW-1:0]    win;
  logic [NM*PW-1:0] ranks;
  beat_e            beat;

  assign arb_point = !busy || last_beat;
  assign elig      = req_i & ~gnt_o;

  arb_rank_regs #(.NM(NM), .PW(PW)) u_ranks (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (rank_wr_i),
    .wr_ranks (rank_i),
    .apply    (arb_point),
    .active   (ranks)
  );

  logic any_elig;

  arb_pick #(.NM(NM), .PW(PW)) u_pick (
    .elig  (elig),
    .ranks (ranks),
    .any   (any_elig),
    .win   (win)
  );

  assign grant_now = arb_point && any_elig;

  arb_beat_seq #(.NM(NM), .AW(AW), .BW(BW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (grant_now),
    .start_idx  (win),
    .start_wide (wide_i[win]),
    .start_addr (addr_i[win*AW +: AW]),
    .start_data (wdata_i[win*WW +: WW]),
    .busy       (busy),
    .last_beat  (last_beat),
    .cur_wide   (cur_wide),
    .beat       (beat),
    .gnt        (gnt_o),
    .dvalid     (dvalid_o),
    .addr_out   (bus_addr_o),
    .data_out   (bus_wdata_o)
  );

  assign bus_valid_o = busy;
  assign bus_hi_o    = (beat == BEAT_HI);
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NM = 4,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] req_i,
  input logic [NM-1:0] gnt_o,
  input logic [NM-1:0] dvalid_o,
  input logic          bus_valid_o,
  input logic          bus_hi_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          last_beat,
  input logic          cur_wide
);
  p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  p_gnt_on_lo_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_o) |-> (bus_valid_o && !bus_hi_o && dvalid_o == gnt_o));

  p_idle_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid_o && |req_i) |=> (|gnt_o));

  p_hi_follows_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_hi_o && cur_wide) |=>
      (bus_valid_o && bus_hi_o && $stable(dvalid_o) && !(|gnt_o)));

  p_hi_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && bus_hi_o) |->
      ($past(bus_valid_o) && !$past(bus_hi_o) && bus_addr_o == $past(bus_addr_o) + AW'(2)));

  p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && |(req_i & ~gnt_o)) |=> (bus_valid_o && !bus_hi_o && |gnt_o));

  p_dvalid_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o ? $onehot(dvalid_o) : (dvalid_o == '0));

  p_no_regrant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_o) |=> !(|(gnt_o & $past(gnt_o))));
endmodule

bind dma_bus_arbiter dma_arb_checker #(.NM(NM), .AW(AW)) i_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .gnt_o       (gnt_o),
  .dvalid_o    (dvalid_o),
  .bus_valid_o (bus_valid_o),
  .bus_hi_o    (bus_hi_o),
  .bus_addr_o  (bus_addr_o),
  .last_beat   (last_beat),
  .cur_wide    (cur_wide)
);

// File: tb/test_dma_bus_arbiter.sv
`timescale 1ns/1ps
module test_dma_bus_arbiter;
  localparam int NM = 4, AW = 16, PW = 3, BW = 16, WW = 32;
  localparam int IL = 1 + AW + WW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [NM-1:0]    req_i = '0, wide_i = '0;
  logic [NM*AW-1:0] addr_i = '0;
  logic [NM*WW-1:0] wdata_i = '0;
  logic             rank_wr_i = 1'b0;
  logic [NM*PW-1:0] rank_i = '0;
  logic [NM-1:0]    gnt_o, dvalid_o;
  logic             bus_valid_o, bus_hi_o;
  logic [AW-1:0]    bus_addr_o;
  logic [BW-1:0]    bus_wdata_o;

  dma_bus_arbiter #(.NM(NM), .AW(AW), .PW(PW), .BW(BW)) i_dma_bus_arbiter (.*);

  // Master agents: one queue of {wide, addr, data} per master.
  logic [IL-1:0] q[NM][$];
  int glog[$];
  int gcyc[$];
  int errors = 0, checks = 0, cyc = 0;
  bit wr_pend = 0;
  logic [NM*PW-1:0] wr_val = '0;

  // Reference model state.
  bit m_busy, m_wide, m_beat;
  int m_owner, m_gnt;
  logic [AW-1:0] m_addr;
  logic [WW-1:0] m_data;
  int act[NM], sh[NM];

  task automatic check(input bit ok, input string r, input string what,
                       input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", r, what, actual, expected, cyc);
    end
  endtask

  function automatic logic [NM-1:0] mask_of(input int idx);
    logic [NM-1:0] m = '0;
    if (idx >= 0) m[idx] = 1'b1;
    return m;
  endfunction

  task automatic model_reset();
    m_busy = 0; m_wide = 0; m_beat = 0; m_owner = 0; m_gnt = -1;
    m_addr = '0; m_data = '0;
    for (int i = 0; i < NM; i++) begin act[i] = i; sh[i] = i; end
  endtask

  task automatic model_next();
    bit last, arb;
    int best;
    last = m_busy && (!m_wide || m_beat);
    arb  = !m_busy || last;
    best = -1;
    for (int i = 0; i < NM; i++)
      if (req_i[i] && m_gnt != i && (best < 0 || act[i] < act[best])) best = i;
    if (arb) for (int i = 0; i < NM; i++) act[i] = sh[i];
    if (rank_wr_i) for (int i = 0; i < NM; i++) sh[i] = int'(rank_i[i*PW +: PW]);
    if (arb && best >= 0) begin
      m_busy = 1; m_beat = 0; m_owner = best; m_gnt = best;
      m_wide = wide_i[best]; m_addr = addr_i[best*AW +: AW]; m_data = wdata_i[best*WW +: WW];
    end else if (m_busy && !last) begin
      m_beat = 1; m_gnt = -1;
    end else begin
      m_busy = 0; m_beat = 0; m_gnt = -1;
    end
  endtask

  task automatic tick();
    logic [AW-1:0] ea;
    @(negedge clk);
    cyc++;
    if (rst_n) begin
      check(gnt_o == mask_of(m_gnt), "R2", "gnt", gnt_o, mask_of(m_gnt));
      check(bus_valid_o == m_busy, "R7", "bus_valid", bus_valid_o, m_busy);
      check(dvalid_o == (m_busy ? mask_of(m_owner) : '0), "R9", "dvalid", dvalid_o,
            m_busy ? mask_of(m_owner) : '0);
      if (m_busy) begin
        ea = m_beat ? m_addr + AW'(2) : m_addr;
        check(bus_hi_o == m_beat, "R6", "bus_hi", bus_hi_o, m_beat);
        check(bus_addr_o == ea, "R5", "bus_addr", bus_addr_o, ea);
        check(bus_wdata_o == (m_beat ? m_data[31:16] : m_data[15:0]), "R5", "bus_wdata",
              bus_wdata_o, m_beat ? m_data[31:16] : m_data[15:0]);
      end
    end
    for (int i = 0; i < NM; i++)
      if (gnt_o[i]) begin glog.push_back(i); gcyc.push_back(cyc); void'(q[i].pop_front()); end
    for (int i = 0; i < NM; i++) begin
      req_i[i] = q[i].size() > 0;
      if (req_i[i]) {wide_i[i], addr_i[i*AW +: AW], wdata_i[i*WW +: WW]} = q[i][0];
      else begin wide_i[i] = 0; addr_i[i*AW +: AW] = '0; wdata_i[i*WW +: WW] = '0; end
    end
    rank_wr_i = wr_pend; rank_i = wr_val; wr_pend = 0;
    if (rst_n) model_next(); else model_reset();
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic push(input int m, input bit w, input int a, input int d);
    q[m].push_back({w, AW'(a), WW'(d)});
  endtask

  task automatic write_ranks(input int r0, input int r1, input int r2, input int r3);
    wr_pend = 1;
    wr_val = {PW'(r3), PW'(r2), PW'(r1), PW'(r0)};
  endtask

  task automatic check_order(input string r, input int e[$]);
    check(glog.size() == e.size(), r, "grant count", glog.size(), e.size());
    for (int i = 0; i < e.size() && i < glog.size(); i++)
      check(glog[i] == e[i], r, "grant order", glog[i], e[i]);
    glog.delete(); gcyc.delete();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    model_reset();
    ticks(3);
    // R1: outputs quiet in reset
    check(gnt_o == 0 && dvalid_o == 0 && bus_valid_o == 0 && bus_hi_o == 0, "R1",
          "reset outputs", {gnt_o, dvalid_o, bus_valid_o, bus_hi_o}, 0);
    rst_n = 1'b1;
    tick();
    check(bus_valid_o == 0 && gnt_o == 0, "R1", "first cycle after reset",
          {gnt_o, bus_valid_o}, 0);

    // R3 and R5: lone 16-bit request granted the next cycle
    push(2, 0, 'h0040, 'h0000_ABCD);
    tick();                                  // request visible
    tick();
    check(gnt_o == 4'b0100, "R3", "grant one cycle after request", gnt_o, 4'b0100);
    check(bus_addr_o == 16'h0040 && bus_wdata_o == 16'hABCD, "R5", "16-bit beat",
          {bus_addr_o, bus_wdata_o}, 32'h0040_ABCD);
    ticks(3); glog.delete(); gcyc.delete();

    // R6: 32-bit transfer in two halves
    push(3, 1, 'h1000, 'hBEEF_1234);
    ticks(2);
    check(bus_addr_o == 16'h1000 && bus_wdata_o == 16'h1234 && !bus_hi_o, "R6",
          "low half", {bus_addr_o, bus_wdata_o}, 32'h1000_1234);
    tick();
    check(bus_addr_o == 16'h1002 && bus_wdata_o == 16'hBEEF && bus_hi_o && gnt_o == 0
          && dvalid_o == 4'b1000, "R6", "high half", {bus_addr_o, bus_wdata_o}, 32'h1002_BEEF);
    ticks(3); glog.delete(); gcyc.delete();

    // R4 and R7: default ranks, all four back to back
    for (int m = 0; m < NM; m++) push(m, 0, 'h100 * m, m);
    ticks(8);
    for (int i = 1; i < gcyc.size(); i++)
      check(gcyc[i] - gcyc[i-1] == 1, "R7", "no idle between grants", gcyc[i] - gcyc[i-1], 1);
    check_order("R4", '{0, 1, 2, 3});

    // R4: reversed ranking written while idle
    write_ranks(3, 2, 1, 0); ticks(3);
    for (int m = 0; m < NM; m++) push(m, 0, 'h200 + m, m);
    ticks(8);
    check_order("R4", '{3, 2, 1, 0});

    // R4: full tie goes to lower index, mixed widths
    write_ranks(5, 5, 5, 5); ticks(3);
    push(2, 1, 'h300, 'h1111_2222); push(1, 1, 'h310, 'h3333_4444);
    push(3, 0, 'h320, 5); push(0, 0, 'h330, 6);
    ticks(10);
    check_order("R4", '{0, 1, 2, 3});

    // R8: a write landing mid-transfer does not steer the arbitration made in the last beat
    write_ranks(0, 1, 2, 3); ticks(3);
    push(0, 1, 'h400, 'h5555_6666);
    tick();
    push(1, 0, 'h410, 1); push(2, 0, 'h420, 2);
    write_ranks(0, 4, 0, 3);
    ticks(8);
    check_order("R8", '{0, 1, 2});
    push(1, 0, 'h430, 3); push(2, 0, 'h440, 4);
    ticks(6);
    check_order("R8", '{2, 1});

    // R10: a held request is not counted in its own grant cycle
    push(0, 0, 'h500, 7); push(0, 0, 'h502, 8);
    ticks(8);
    check(gcyc.size() == 2 && gcyc[1] - gcyc[0] == 2, "R10", "regrant spacing",
          gcyc.size() == 2 ? gcyc[1] - gcyc[0] : -1, 2);
    glog.delete(); gcyc.delete();

    // Mixed random traffic with rank rewrites at any beat, compared every cycle
    for (int k = 0; k < 3000; k++) begin
      for (int m = 0; m < NM; m++)
        if (q[m].size() < 3 && ($urandom % 5) == 0)
          push(m, 1'($urandom), int'($urandom % 65536), int'($urandom));
      if (($urandom % 40) == 0)
        write_ranks(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
      tick();
    end
    ticks(40);
    glog.delete(); gcyc.delete();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule